// File: doc/BRIEF.md
# NAND Flash Register Interface with Running ECC

This block sits between a processor's register bus and a raw 8-bit NAND flash device. Software steers the flash by writing a control register, whose bits drive the command-latch, address-latch, chip-enable and write-protect lines. It moves command, address and data bytes through a single data port. Every write to the data port produces one single-cycle write strobe toward the flash. Every read of the data port produces one single-cycle read strobe, or two of them for a 32-bit access.

While bytes move, an accumulator builds a Hamming-style code for a 256-byte block. It keeps a column parity computed from bit-position parities, two line-parity bytes driven by the byte index, and a byte counter. Software reads these back to compare against the stored code and clears them before each new block. Error correction itself is left to software.

Register reads answer with a one-cycle `reg_rvalid` pulse. The master issues one access at a time and waits for the answer to a read before the next access.

Top module: `nand_regif`

## Requirements
- R1: Offsets are 0x00 line-parity-low, 0x04 line-parity-high, 0x08 column parity, 0x0C byte counter, 0x10 code clear, 0x14 flash data, 0x18 control. Reads of any other offset return zero, and writes to any other offset change no readable register or flash pin.
- R2: A control write stores wdata[7:0] with bit 5 forced to 0. A control read returns the stored byte with bit 5 replaced by the `fl_rdy` input level.
- R3: The pins follow the control register: `fl_cle` = bit 1, `fl_ale` = bit 2, `fl_wp` = bit 3. `fl_ce_n` is high (flash deselected) when bit 0 or bit 4 is set.
- R4: A data-port write drives `fl_we_n` low for exactly one cycle, starting the cycle after the strobe edge. During that cycle `fl_io_oe` is high and `fl_io_o` carries wdata[7:0].
- R5: An 8-bit data-port read gives one single-cycle `fl_re_n` low pulse and samples `fl_io_i` at the edge that ends it. It returns the byte in rdata[7:0] with all other bits zero, and `reg_rvalid` comes at the second falling edge after the strobe is driven.
- R6: A 32-bit data-port read gives two `fl_re_n` pulses separated by one high cycle. The first byte goes to rdata[7:0] and the second to rdata[23:16], all other bits are zero, and `reg_rvalid` comes at the fourth falling edge.
- R7: Every byte written or read through the data port advances the byte counter by one. The counter reads back as its low 8 bits, so it wraps at 256 on the bus.
- R8: Column parity is 6 bits in rdata[5:0]. For k = 0,1,2, bit 2k toggles with the parity of the data bits whose index has bit k clear, and bit 2k+1 with those whose index has bit k set.
- R9: For a byte of odd overall parity, internal line byte A is XORed with the byte index (counter low 8 bits) and line byte B with its inverse. Line-parity-low places A[4+k] at bit 2k and B[4+k] at bit 2k+1. Line-parity-high does the same with A[k] and B[k].
- R10: Any write to the clear offset zeroes both line bytes, the column parity and the counter, whatever the data.
- R11: After reset the control register is zero (`fl_ce_n`, `fl_cle`, `fl_ale`, `fl_wp` low), the code state is zero, both flash strobes are high, `fl_io_oe` is low and `reg_rvalid` is low.
- R12: A read of any offset other than the data port answers at the first falling edge after the strobe is driven, using state from before the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wide | input | 1 | 1 = 32-bit read, 0 = 8-bit read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data, low byte used |
| reg_rdata | output | 32 | Read data, held until the next answer |
| reg_rvalid | output | 1 | One-cycle pulse when reg_rdata is new |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_wp | output | 1 | Write-protect level from the control register |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_re_n | output | 1 | Flash read strobe, active low |
| fl_io_o | output | 8 | Flash I/O bus, driven value |
| fl_io_i | input | 8 | Flash I/O bus, received value |
| fl_io_oe | output | 1 | Flash I/O bus output enable |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench counts falling edges from the driven strobe to `reg_rvalid` and requires 1 for plain registers, 2 for a byte read of the data port and 4 for a 32-bit one. It takes the data only at that edge. For a data-port write, the flash pins are checked at the first falling edge, where the write pulse must be present, and again at the second, where it must be gone. Code registers are read only after the previous access has answered, so each value includes every byte moved before it.

// File: rtl/nand_regif_pkg.sv
// Package: shared offsets, control bit indices and sequencer states for
// the NAND register interface. Assumes an 8-bit offset space.
package nand_regif_pkg;
    localparam logic [7:0] OFS_LP_LO = 8'h00;
    localparam logic [7:0] OFS_LP_HI = 8'h04;
    localparam logic [7:0] OFS_CPAR  = 8'h08;
    localparam logic [7:0] OFS_CNT   = 8'h0C;
    localparam logic [7:0] OFS_CLR   = 8'h10;
    localparam logic [7:0] OFS_DATA  = 8'h14;
    localparam logic [7:0] OFS_CTL   = 8'h18;

    localparam int CTL_CE0 = 0;
    localparam int CTL_CLE = 1;
    localparam int CTL_ALE = 2;
    localparam int CTL_WP  = 3;
    localparam int CTL_CE1 = 4;
    localparam int CTL_RDY = 5;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RD1  = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_RD2  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/nand_ecc_acc.sv
// Running Hamming-style code over bytes moved through the data port.
// Keeps column parity, two line-parity bytes and a byte counter, and
// presents the line bytes interleaved across two readback words.
// Assumes clr and feed are never high in the same cycle (clr wins).
module nand_ecc_acc #(
    parameter int BYTE_W = 8,
    parameter int LP_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              feed,
    input  logic [BYTE_W-1:0] feed_byte,
    output logic [LP_W-1:0]   lp_lo_rd,
    output logic [LP_W-1:0]   lp_hi_rd,
    output logic [BYTE_W-1:0] cp_rd,
    output logic [BYTE_W-1:0] cnt_rd
);
    localparam int COL_LOG = $clog2(BYTE_W);
    localparam int CP_W    = 2 * COL_LOG;
    localparam int HALF    = LP_W / 2;

    logic [LP_W-1:0]  lpa_q, lpb_q;
    logic [CP_W-1:0]  cp_q, cp_step;
    logic [CNT_W-1:0] cnt_q;

    // Column parity contribution of the incoming byte.
    always_comb begin
        cp_step = '0;
        for (int k = 0; k < COL_LOG; k++) begin
            for (int j = 0; j < BYTE_W; j++) begin
                if (feed_byte[j]) begin
                    cp_step[2*k + ((j >> k) & 1)] = ~cp_step[2*k + ((j >> k) & 1)];
                end
            end
        end
    end

    // Accumulate code state per byte, clear on request or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lpa_q <= '0;
            lpb_q <= '0;
            cp_q  <= '0;
            cnt_q <= '0;
        end else if (feed) begin
            cnt_q <= cnt_q + 1'b1;
            cp_q  <= cp_q ^ cp_step;
            if (^feed_byte) begin
                lpa_q <= lpa_q ^ cnt_q[LP_W-1:0];
                lpb_q <= lpb_q ^ ~cnt_q[LP_W-1:0];
            end
        end
    end

    // Interleave the two line bytes: upper halves low word, lower halves high word.
    for (genvar g = 0; g < HALF; g++) begin : g_ilv
        assign lp_lo_rd[2*g]   = lpa_q[HALF+g];
        assign lp_lo_rd[2*g+1] = lpb_q[HALF+g];
        assign lp_hi_rd[2*g]   = lpa_q[g];
        assign lp_hi_rd[2*g+1] = lpb_q[g];
    end

    assign cp_rd  = {{(BYTE_W-CP_W){1'b0}}, cp_q};
    assign cnt_rd = cnt_q[BYTE_W-1:0];

    // R7: each fed byte moves the counter by exactly one.
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && !clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R9: a byte of even parity leaves both line bytes alone.
    a_r9_even_keeps_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && !clr && !(^feed_byte)) |=> ($stable(lpa_q) && $stable(lpb_q)));
    // R10: a clear leaves the whole code state at zero.
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && cp_q == '0 && lpa_q == '0 && lpb_q == '0));
endmodule

// File: rtl/nand_ctl_reg.sv
// Control register: stores the flash pin levels written by software and
// drives them out. The ready bit is never stored; reads substitute the
// live ready input. Assumes the write strobe lasts one cycle.
module nand_ctl_reg #(
    parameter int CTL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             rdy,
    output logic [CTL_W-1:0] ctl_rd,
    output logic             fl_cle,
    output logic             fl_ale,
    output logic             fl_ce_n,
    output logic             fl_wp
);
    import nand_regif_pkg::*;

    localparam logic [CTL_W-1:0] RDY_MASK = CTL_W'(1) << CTL_RDY;

    logic [CTL_W-1:0] ctl_q;

    // Store the written byte with the ready position cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata & ~RDY_MASK;
        end
    end

    assign ctl_rd  = ctl_q | (rdy ? RDY_MASK : '0);
    assign fl_cle  = ctl_q[CTL_CLE];
    assign fl_ale  = ctl_q[CTL_ALE];
    assign fl_wp   = ctl_q[CTL_WP];
    assign fl_ce_n = ctl_q[CTL_CE0] | ctl_q[CTL_CE1];

    // R2: without a write the stored control byte does not move.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ctl_q));
endmodule

// File: rtl/nand_io_seq.sv
// Flash strobe sequencer: turns data-port accesses into single-cycle
// write or read strobes, samples returned bytes and assembles the word
// for 8-bit or 32-bit reads. Assumes no new access while busy is high.
module nand_io_seq #(
    parameter int FL_W   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic              rd_wide,
    input  logic [FL_W-1:0]   wbyte,
    input  logic [FL_W-1:0]   fl_io_i,
    output logic [FL_W-1:0]   fl_io_o,
    output logic              fl_io_oe,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic              busy,
    output logic              smp_valid,
    output logic [FL_W-1:0]   smp_byte,
    output logic              done,
    output logic [DATA_W-1:0] done_word
);
    import nand_regif_pkg::*;

    localparam int HI_POS = 2 * FL_W;

    seq_state_e      state_q;
    logic            wide_q;
    logic [FL_W-1:0] first_q;

    // Step the read sequence and shape the write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            wide_q   <= 1'b0;
            first_q  <= '0;
            fl_io_o  <= '0;
            fl_io_oe <= 1'b0;
            fl_we_n  <= 1'b1;
            fl_re_n  <= 1'b1;
        end else begin
            fl_we_n  <= 1'b1;
            fl_io_oe <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (wr_go) begin
                        fl_io_o  <= wbyte;
                        fl_io_oe <= 1'b1;
                        fl_we_n  <= 1'b0;
                    end else if (rd_go) begin
                        fl_re_n <= 1'b0;
                        wide_q  <= rd_wide;
                        state_q <= SEQ_RD1;
                    end
                end
                SEQ_RD1: begin
                    fl_re_n <= 1'b1;
                    first_q <= fl_io_i;
                    state_q <= wide_q ? SEQ_GAP : SEQ_IDLE;
                end
                SEQ_GAP: begin
                    fl_re_n <= 1'b0;
                    state_q <= SEQ_RD2;
                end
                default: begin
                    fl_re_n <= 1'b1;
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Sampling and completion indications for the current cycle.
    always_comb begin
        smp_valid = (state_q == SEQ_RD1) || (state_q == SEQ_RD2);
        smp_byte  = fl_io_i;
        done      = ((state_q == SEQ_RD1) && !wide_q) || (state_q == SEQ_RD2);
        done_word = '0;
        if (state_q == SEQ_RD2) begin
            done_word[FL_W-1:0]          = first_q;
            done_word[HI_POS +: FL_W]    = fl_io_i;
        end else begin
            done_word[FL_W-1:0]          = fl_io_i;
        end
    end

    assign busy = (state_q != SEQ_IDLE) || !fl_we_n;

    // R4: a write strobe lasts exactly one cycle.
    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |=> fl_we_n);
    // R4: the bus is driven whenever the write strobe is low.
    a_r4_oe_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_io_oe);
    // R5: a read strobe lasts exactly one cycle.
    a_r5_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |=> fl_re_n);
    // R5: never both strobes at once, and no bus drive during a read.
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_re_n |-> (fl_we_n && !fl_io_oe));
endmodule

// File: rtl/nand_regif.sv
// NAND flash register interface top: decodes the register bus, routes
// writes to the control register, the code clear and the strobe
// sequencer, feeds every data-port byte to the code accumulator and
// returns read data with a one-cycle valid pulse. Assumes one access at
// a time: no strobe until the previous read has answered.
module nand_regif #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int FL_W   = 8,
    parameter int LP_W   = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_wide,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_ce_n,
    output logic              fl_wp,
    output logic              fl_we_n,
    output logic              fl_re_n,
    output logic [FL_W-1:0]   fl_io_o,
    input  logic [FL_W-1:0]   fl_io_i,
    output logic              fl_io_oe,
    input  logic              fl_rdy
);
    import nand_regif_pkg::*;

    logic              hit_data, hit_ctl, hit_clr, hit_known;
    logic              ctl_we, ecc_clr, wr_go, rd_go;
    logic [FL_W-1:0]   ctl_rd, lp_lo, lp_hi, cp_val, cnt_val;
    logic              io_busy, smp_valid, seq_done;
    logic [FL_W-1:0]   smp_byte;
    logic [DATA_W-1:0] seq_word, reg_val;
    logic              ecc_feed;
    logic [FL_W-1:0]   ecc_byte;

    // Offset decode and strobe routing.
    always_comb begin
        hit_data  = (reg_addr == ADDR_W'(OFS_DATA));
        hit_ctl   = (reg_addr == ADDR_W'(OFS_CTL));
        hit_clr   = (reg_addr == ADDR_W'(OFS_CLR));
        hit_known = hit_data || hit_ctl || hit_clr ||
                    (reg_addr == ADDR_W'(OFS_LP_LO)) ||
                    (reg_addr == ADDR_W'(OFS_LP_HI)) ||
                    (reg_addr == ADDR_W'(OFS_CPAR))  ||
                    (reg_addr == ADDR_W'(OFS_CNT));
        ctl_we    = reg_wr && hit_ctl;
        ecc_clr   = reg_wr && hit_clr;
        wr_go     = reg_wr && hit_data;
        rd_go     = reg_rd && hit_data;
        ecc_feed  = wr_go || smp_valid;
        ecc_byte  = wr_go ? reg_wdata[FL_W-1:0] : smp_byte;
    end

    // Readback multiplexer for the non-data registers.
    always_comb begin
        reg_val = '0;
        case (reg_addr)
            ADDR_W'(OFS_LP_LO): reg_val = DATA_W'(lp_lo);
            ADDR_W'(OFS_LP_HI): reg_val = DATA_W'(lp_hi);
            ADDR_W'(OFS_CPAR):  reg_val = DATA_W'(cp_val);
            ADDR_W'(OFS_CNT):   reg_val = DATA_W'(cnt_val);
            ADDR_W'(OFS_CTL):   reg_val = DATA_W'(ctl_rd);
            default:            reg_val = '0;
        endcase
    end

    // Capture read answers and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= 1'b0;
            if (seq_done) begin
                reg_rdata  <= seq_word;
                reg_rvalid <= 1'b1;
            end else if (reg_rd && !hit_data) begin
                reg_rdata  <= reg_val;
                reg_rvalid <= 1'b1;
            end
        end
    end

    nand_ctl_reg #(.CTL_W(FL_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .wdata   (reg_wdata[FL_W-1:0]),
        .rdy     (fl_rdy),
        .ctl_rd  (ctl_rd),
        .fl_cle  (fl_cle),
        .fl_ale  (fl_ale),
        .fl_ce_n (fl_ce_n),
        .fl_wp   (fl_wp)
    );

    nand_io_seq #(.FL_W(FL_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .rd_wide   (reg_wide),
        .wbyte     (reg_wdata[FL_W-1:0]),
        .fl_io_i   (fl_io_i),
        .fl_io_o   (fl_io_o),
        .fl_io_oe  (fl_io_oe),
        .fl_we_n   (fl_we_n),
        .fl_re_n   (fl_re_n),
        .busy      (io_busy),
        .smp_valid (smp_valid),
        .smp_byte  (smp_byte),
        .done      (seq_done),
        .done_word (seq_word)
    );

    nand_ecc_acc #(.BYTE_W(FL_W), .LP_W(LP_W), .CNT_W(CNT_W)) u_ecc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ecc_clr),
        .feed      (ecc_feed),
        .feed_byte (ecc_byte),
        .lp_lo_rd  (lp_lo),
        .lp_hi_rd  (lp_hi),
        .cp_rd     (cp_val),
        .cnt_rd    (cnt_val)
    );

    // R12: the master keeps the bus quiet while a flash transfer runs.
    a_r12_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        io_busy |-> !(reg_wr || reg_rd));
    // R1: an unmapped read answers with zero in the next cycle.
    a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !hit_known) |=> (reg_rvalid && reg_rdata == '0));
    // R1: never both bus strobes in the same cycle.
    a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

// File: tb/nand_regif_bench.sv
`timescale 1ns/1ps
module nand_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_wide = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        fl_cle, fl_ale, fl_ce_n, fl_wp, fl_we_n, fl_re_n, fl_io_oe;
    logic [7:0]  fl_io_o, fl_io_i;
    logic        fl_rdy = 1'b0;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    nand_regif u_nand_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_wp(fl_wp),
        .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_io_o(fl_io_o),
        .fl_io_i(fl_io_i), .fl_io_oe(fl_io_oe), .fl_rdy(fl_rdy)
    );

    // Flash model: a counter advanced on every read strobe picks the byte.
    logic [7:0] fm_idx = '0;
    assign fl_io_i = fm_idx * 8'd29 + 8'd7;
    always @(posedge clk) if (!fl_re_n) fm_idx <= fm_idx + 8'd1;

    // Reference code state computed from the requirements.
    int         m_cnt = 0;
    logic [7:0] m_la = '0, m_lb = '0;
    logic [5:0] m_cp = '0;

    function automatic logic [7:0] flash_byte(input logic [7:0] i);
        return i * 8'd29 + 8'd7;
    endfunction

    task automatic m_feed(input logic [7:0] b);
        logic [7:0] ix = m_cnt[7:0];
        if (^b) begin
            m_la = m_la ^ ix;
            m_lb = m_lb ^ ~ix;
        end
        for (int j = 0; j < 8; j++)
            if (b[j])
                for (int k = 0; k < 3; k++)
                    m_cp[2*k + ((j >> k) & 1)] = ~m_cp[2*k + ((j >> k) & 1)];
        m_cnt++;
    endtask

    task automatic m_clear();
        m_cnt = 0; m_la = '0; m_lb = '0; m_cp = '0;
    endtask

    function automatic logic [7:0] weave(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k]   = a[k];
            r[2*k+1] = b[k];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic wide,
                           output logic [31:0] d, output int lat);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_wide = wide;
        @(negedge clk);
        reg_rd = 1'b0; reg_wide = 1'b0;
        lat = 1;
        while (!reg_rvalid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        d = reg_rdata;
    endtask

    task automatic data_write(input logic [7:0] b);
        do_write(8'h14, {24'h0, b});
        m_feed(b);
    endtask

    task automatic check_code(input string tag);
        logic [31:0] d;
        int lat;
        do_read(8'h00, 1'b0, d, lat);
        check({tag, " R9 line-low"}, d, {24'h0, weave(m_la[7:4], m_lb[7:4])});
        do_read(8'h04, 1'b0, d, lat);
        check({tag, " R9 line-high"}, d, {24'h0, weave(m_la[3:0], m_lb[3:0])});
        do_read(8'h08, 1'b0, d, lat);
        check({tag, " R8 column"}, d, {26'h0, m_cp});
        do_read(8'h0C, 1'b0, d, lat);
        check({tag, " R7 count"}, d, {24'h0, m_cnt[7:0]});
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Register vectors: [24] write, [23:16] offset, [15:8] data, [7:0] expected read.
    localparam logic [24:0] VEC [13] = '{
        {1'b1, 8'h18, 8'hFF, 8'h00},
        {1'b0, 8'h18, 8'h00, 8'hDF},
        {1'b1, 8'h18, 8'h06, 8'h00},
        {1'b0, 8'h18, 8'h00, 8'h06},
        {1'b0, 8'h1C, 8'h00, 8'h00},
        {1'b1, 8'h1C, 8'hAA, 8'h00},
        {1'b0, 8'h18, 8'h00, 8'h06},
        {1'b0, 8'h00, 8'h00, 8'h00},
        {1'b0, 8'h08, 8'h00, 8'h00},
        {1'b0, 8'h0C, 8'h00, 8'h00},
        {1'b0, 8'h40, 8'h00, 8'h00},
        {1'b1, 8'h10, 8'h5A, 8'h00},
        {1'b0, 8'h0C, 8'h00, 8'h00}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  e0, e1, idx0;
        int lat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state at the pins.
        check("R11 pins", {24'h0, fl_ce_n, fl_cle, fl_ale, fl_wp, fl_we_n, fl_re_n, fl_io_oe, reg_rvalid},
              {24'h0, 8'b0000_1100});

        // R1 R2 R12: register vector table.
        for (int i = 0; i < 13; i++) begin
            if (VEC[i][24]) begin
                do_write(VEC[i][23:16], {24'h0, VEC[i][15:8]});
            end else begin
                do_read(VEC[i][23:16], 1'b0, d, lat);
                check($sformatf("R1 R2 table row %0d", i), d, {24'h0, VEC[i][7:0]});
                check($sformatf("R12 latency row %0d", i), lat, 1);
            end
        end
        // R1: the ignored write left the pins as the control register says.
        check("R1 pins after unmapped write", {28'h0, fl_ce_n, fl_cle, fl_ale, fl_wp}, 32'h6);

        // R3: pin mapping.
        do_write(8'h18, 32'h01);
        check("R3 CE0 deselects", {31'h0, fl_ce_n}, 32'h1);
        do_write(8'h18, 32'h10);
        check("R3 CE1 deselects", {31'h0, fl_ce_n}, 32'h1);
        do_write(8'h18, 32'h08);
        check("R3 wp only", {28'h0, fl_ce_n, fl_cle, fl_ale, fl_wp}, 32'h1);
        do_write(8'h18, 32'h00);

        // R2: live ready level in bit 5.
        fl_rdy = 1'b1;
        do_read(8'h18, 1'b0, d, lat);
        check("R2 ready high", d, 32'h20);
        fl_rdy = 1'b0;
        do_read(8'h18, 1'b0, d, lat);
        check("R2 ready low", d, 32'h00);

        // R4: one data write and its pulse.
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0000_A1C3;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R4 pulse", {22'h0, fl_we_n, fl_re_n, fl_io_oe, fl_io_o, 1'b0}, {22'h0, 1'b0, 1'b1, 1'b1, 8'hC3, 1'b0});
        m_feed(8'hC3);
        @(negedge clk);
        check("R4 pulse ends", {30'h0, fl_we_n, fl_io_oe}, 32'h2);

        // R5: byte read.
        idx0 = fm_idx;
        e0 = flash_byte(idx0);
        do_read(8'h14, 1'b0, d, lat);
        check("R5 byte data", d, {24'h0, e0});
        check("R5 latency", lat, 2);
        check("R5 one strobe", {24'h0, fm_idx}, {24'h0, idx0 + 8'd1});
        m_feed(e0);

        // R6: wide read.
        idx0 = fm_idx;
        e0 = flash_byte(idx0);
        e1 = flash_byte(idx0 + 8'd1);
        do_read(8'h14, 1'b1, d, lat);
        check("R6 wide data", d, {8'h0, e1, 8'h0, e0});
        check("R6 latency", lat, 4);
        check("R6 two strobes", {24'h0, fm_idx}, {24'h0, idx0 + 8'd2});
        m_feed(e0);
        m_feed(e1);
        check_code("mixed traffic");

        // R10: clear with all-ones data.
        do_write(8'h10, 32'hFFFF_FFFF);
        m_clear();
        check_code("R10 after clear");

        // R8 R9: single byte 0x01 at index 0.
        data_write(8'h01);
        do_read(8'h08, 1'b0, d, lat);
        check("R8 column after 0x01", d, 32'h15);
        do_read(8'h00, 1'b0, d, lat);
        check("R9 line-low after 0x01", d, 32'hAA);
        data_write(8'h03);
        check_code("R8 even byte");

        // R9: odd byte at index 0x35 gives asymmetric line bytes.
        do_write(8'h10, 32'h0);
        m_clear();
        for (int i = 0; i < 'h35; i++) data_write(8'h00);
        data_write(8'h80);
        do_read(8'h00, 1'b0, d, lat);
        check("R9 interleave low", d, 32'hA5);
        do_read(8'h04, 1'b0, d, lat);
        check("R9 interleave high", d, 32'h99);
        do_read(8'h08, 1'b0, d, lat);
        check("R8 column after 0x80", d, 32'h2A);

        // R7: counter wraps past 256 on the bus.
        for (int i = 0; i < 250; i++) data_write(8'h00);
        do_read(8'h0C, 1'b0, d, lat);
        check("R7 count wrap", d, 32'h30);
        check_code("after wrap");

        finish_up();
    end
endmodule